// File: doc/BRIEF.md
# Lane-Mask Divergence Stack

This block tracks which lanes of a 16-lane SIMD thread are enabled while the thread runs through data-dependent branches. A compare unit presents one predicate bit per lane, set for lanes whose element is non-zero. On a divergent branch the controller pushes a frame and narrows the enabled set to the lanes taking the if path. A later switch command enables the lanes of the saved set whose predicate was clear, which is the else path. At the reconvergence point a pop brings back the saved set. Each frame holds a label token, a reconvergence target address and the mask that was active before the branch. Selections may nest, up to the depth of the per-thread stack.

The block also tells the issue logic when a clause can be skipped: if no enabled lane has its predicate set, the if clause need not be issued, and if no enabled lane has it clear, the else clause need not be issued. For data-dependent loops, an exit command removes the lanes whose predicate is set from the active mask, and a convergence flag rises once no lane is left running. Misuse of the stack is recorded in two sticky error flags.

Top module: `simt_div_stack`

## Requirements
- R1: After reset the active mask is all ones, depth is 0, both error flags are 0, on_else is 0 and top_tok/top_tgt read 0.
- R2: A push (cmd_op=1) with depth below 8 stores {tok_in, tgt_in, current mask} as a new top frame, raises depth by one and sets the mask to mask & pred. The new frame shows top_tok/top_tgt and on_else=0.
- R3: A switch (cmd_op=2) with depth above 0 sets the mask to saved & ~mask, where saved is the top frame's mask, and sets on_else to 1. Depth is unchanged.
- R4: A pop (cmd_op=3) with depth above 0 restores the mask from the top frame and lowers depth by one.
- R5: skip_if is 1 exactly when (mask & pred) is 0, and skip_else is 1 exactly when (mask & ~pred) is 0, for the pred value currently on the input.
- R6: Frames nest last-in first-out up to 8 deep; after a pop, top_tok, top_tgt and on_else show the frame beneath.
- R7: A push at depth 8 changes no state except setting ovf_err, which then stays 1 until reset.
- R8: A switch or pop at depth 0 changes no state except setting unf_err, which then stays 1 until reset.
- R9: An exit (cmd_op=4) sets the mask to mask & ~pred without touching the stack; converged is 1 exactly when the mask is 0.
- R10: A no-op (cmd_op=0, or 5 to 7) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 push, 2 switch to else, 3 pop, 4 loop exit |
| pred | input | 16 | Per-lane predicate from the compare |
| tok_in | input | 4 | Label token stored by a push |
| tgt_in | input | 12 | Reconvergence address stored by a push |
| active_mask | output | 16 | Lanes currently enabled |
| skip_if | output | 1 | No enabled lane takes the if path |
| skip_else | output | 1 | No enabled lane takes the else path |
| on_else | output | 1 | Top frame has been switched to its else path |
| depth | output | 4 | Number of frames on the stack |
| top_tok | output | 4 | Token of the top frame |
| top_tgt | output | 12 | Target address of the top frame |
| ovf_err | output | 1 | Sticky: push attempted on a full stack |
| unf_err | output | 1 | Sticky: switch or pop attempted on an empty stack |
| converged | output | 1 | Active mask is all zero |

## Verification
The hardest state to reach is a full stack of eight frames whose saved masks all differ, followed by an overflow attempt and an unwind that must return every mask and token in reverse order. A directed sequence pushes eight frames with distinct tokens and predicates, attempts a ninth push, then pops down past empty. A long pseudo-random command stream, mixed with all-zero and all-one predicates and periodic resets, drives switches and exits at every depth while a bench-side stack model predicts every output.

// File: rtl/dms_pkg.sv
package dms_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_SWAP = 3'd2,
    OP_POP  = 3'd3,
    OP_EXIT = 3'd4
  } op_e;
endpackage

// File: rtl/dms_frame_stack.sv
module dms_frame_stack #(
  parameter int DEPTH = 8,
  parameter int LANES = 16,
  parameter int TOKW  = 4,
  parameter int ADDRW = 12,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic             mark_else,
  input  logic [TOKW-1:0]  push_tok,
  input  logic [ADDRW-1:0] push_tgt,
  input  logic [LANES-1:0] push_mask,
  output logic [TOKW-1:0]  top_tok,
  output logic [ADDRW-1:0] top_tgt,
  output logic [LANES-1:0] top_mask,
  output logic             top_else,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [TOKW-1:0]  tok_q [DEPTH];
  logic [TOKW-1:0]  tok_d [DEPTH];
  logic [ADDRW-1:0] tgt_q [DEPTH];
  logic [ADDRW-1:0] tgt_d [DEPTH];
  logic [LANES-1:0] msk_q [DEPTH];
  logic [LANES-1:0] msk_d [DEPTH];
  logic [DEPTH-1:0] els_q, els_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IW-1:0]    wr_idx, top_idx;

  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;

  always_comb begin
    tok_d = tok_q;
    tgt_d = tgt_q;
    msk_d = msk_q;
    els_d = els_q;
    cnt_d = cnt_q;
    if (push_en) begin
      tok_d[wr_idx] = push_tok;
      tgt_d[wr_idx] = push_tgt;
      msk_d[wr_idx] = push_mask;
      els_d[wr_idx] = 1'b0;
      cnt_d         = cnt_q + CW'(1);
    end else if (pop_en) begin
      cnt_d = cnt_q - CW'(1);
    end else if (mark_else) begin
      els_d[top_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      els_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tok_q[i] <= '0;
        tgt_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else if (push_en || pop_en || mark_else) begin
      cnt_q <= cnt_d;
      els_q <= els_d;
      tok_q <= tok_d;
      tgt_q <= tgt_d;
      msk_q <= msk_d;
    end
  end

  assign top_tok  = empty ? '0 : tok_q[top_idx];
  assign top_tgt  = empty ? '0 : tgt_q[top_idx];
  assign top_mask = empty ? '0 : msk_q[top_idx];
  assign top_else = empty ? 1'b0 : els_q[top_idx];

  p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_push_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> (top_tok == $past(push_tok)) && (top_tgt == $past(push_tgt)) && !top_else);
  p_pop_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/dms_mask_ctrl.sv
module dms_mask_ctrl #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dms_pkg::op_e     op,
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] top_mask,
  input  logic             full,
  input  logic             empty,
  output logic [LANES-1:0] mask,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             swap_ok,
  output logic             skip_if,
  output logic             skip_else,
  output logic             ovf,
  output logic             unf
);
  import dms_pkg::*;

  logic [LANES-1:0] mask_q, mask_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic             mask_en;

  assign push_ok = (op == OP_PUSH) && !full;
  assign pop_ok  = (op == OP_POP)  && !empty;
  assign swap_ok = (op == OP_SWAP) && !empty;

  always_comb begin
    mask_d = mask_q;
    unique case (1'b1)
      push_ok:          mask_d = mask_q & pred;
      swap_ok:          mask_d = top_mask & ~mask_q;
      pop_ok:           mask_d = top_mask;
      (op == OP_EXIT):  mask_d = mask_q & ~pred;
      default:          mask_d = mask_q;
    endcase
    mask_en = push_ok || swap_ok || pop_ok || (op == OP_EXIT);
    ovf_d   = ovf_q || ((op == OP_PUSH) && full);
    unf_d   = unf_q || (((op == OP_POP) || (op == OP_SWAP)) && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign mask      = mask_q;
  assign ovf       = ovf_q;
  assign unf       = unf_q;
  assign skip_if   = ((mask_q & pred) == '0);
  assign skip_else = ((mask_q & ~pred) == '0);

  always_comb begin
    if (rst_n && (mask_q != '0)) begin
      a_skip_excl_r5: assert (!(skip_if && skip_else));
    end
  end

  p_push_narrows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> ((mask_q & ~$past(mask_q)) == '0));
  p_swap_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ok |=> ((mask_q & $past(mask_q)) == '0));
  p_pop_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> (mask_q == $past(top_mask)));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int LANES = 16,
  parameter int DEPTH = 8,
  parameter int TOKW  = 4,
  parameter int ADDRW = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_op,
  input  logic [LANES-1:0] pred,
  input  logic [TOKW-1:0]  tok_in,
  input  logic [ADDRW-1:0] tgt_in,
  output logic [LANES-1:0] active_mask,
  output logic             skip_if,
  output logic             skip_else,
  output logic             on_else,
  output logic [CW-1:0]    depth,
  output logic [TOKW-1:0]  top_tok,
  output logic [ADDRW-1:0] top_tgt,
  output logic             ovf_err,
  output logic             unf_err,
  output logic             converged
);
  dms_pkg::op_e     op;
  logic [LANES-1:0] top_mask;
  logic             full, empty, push_ok, pop_ok, swap_ok;

  assign op = dms_pkg::op_e'(cmd_op);

  dms_mask_ctrl #(.LANES(LANES)) u_mask (
    .clk(clk), .rst_n(rst_n), .op(op), .pred(pred), .top_mask(top_mask),
    .full(full), .empty(empty), .mask(active_mask), .push_ok(push_ok),
    .pop_ok(pop_ok), .swap_ok(swap_ok), .skip_if(skip_if),
    .skip_else(skip_else), .ovf(ovf_err), .unf(unf_err)
  );

  dms_frame_stack #(.DEPTH(DEPTH), .LANES(LANES), .TOKW(TOKW), .ADDRW(ADDRW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_en(push_ok), .pop_en(pop_ok),
    .mark_else(swap_ok), .push_tok(tok_in), .push_tgt(tgt_in),
    .push_mask(active_mask), .top_tok(top_tok), .top_tgt(top_tgt),
    .top_mask(top_mask), .top_else(on_else), .count(depth),
    .full(full), .empty(empty)
  );

  assign converged = (active_mask == '0);

  p_exit_no_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4) |=> $stable(depth));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_op == 3'd0) || (cmd_op > 3'd4)) |=> $stable(active_mask) && $stable(depth));
endmodule

// File: tb/tb_simt_div_stack.sv
module tb_simt_div_stack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd_op;
  logic [15:0] pred;
  logic [3:0]  tok_in;
  logic [11:0] tgt_in;
  logic [15:0] active_mask;
  logic        skip_if, skip_else, on_else, ovf_err, unf_err, converged;
  logic [3:0]  depth, top_tok;
  logic [11:0] top_tgt;

  simt_div_stack dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [3:0]  m_tok [8];
  logic [11:0] m_tgt [8];
  logic [15:0] m_msk [8];
  logic        m_els [8];
  int          m_dep;
  logic [15:0] m_mask;
  logic        m_ovf, m_unf;
  logic [31:0] lfsr = 32'hACE1_1234;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_dep = 0; m_mask = 16'hFFFF; m_ovf = 0; m_unf = 0;
    for (int i = 0; i < 8; i++) begin m_els[i] = 0; m_tok[i] = 0; m_tgt[i] = 0; m_msk[i] = 0; end
  endtask

  task automatic check_state(input string req);
    chk(req, "mask", {16'd0, active_mask}, {16'd0, m_mask});
    chk(req, "depth", {28'd0, depth}, m_dep);
    chk(req, "tok", {28'd0, top_tok}, (m_dep > 0) ? {28'd0, m_tok[m_dep-1]} : 32'd0);
    chk(req, "tgt", {20'd0, top_tgt}, (m_dep > 0) ? {20'd0, m_tgt[m_dep-1]} : 32'd0);
    chk(req, "on_else", {31'd0, on_else}, (m_dep > 0) ? {31'd0, m_els[m_dep-1]} : 32'd0);
    chk("R7", "ovf", {31'd0, ovf_err}, {31'd0, m_ovf});
    chk("R8", "unf", {31'd0, unf_err}, {31'd0, m_unf});
    chk("R9", "converged", {31'd0, converged}, {31'd0, (m_mask == 16'd0)});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_op = 3'd0; pred = '0; tok_in = '0; tgt_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    #1 check_state("R1");
  endtask

  task automatic step(input logic [2:0] op, input logic [15:0] p, input logic [3:0] t, input logic [11:0] a);
    string req;
    @(negedge clk);
    cmd_op = op; pred = p; tok_in = t; tgt_in = a;
    #1;
    chk("R5", "skip_if", {31'd0, skip_if}, {31'd0, ((m_mask & p) == 16'd0)});
    chk("R5", "skip_else", {31'd0, skip_else}, {31'd0, ((m_mask & ~p) == 16'd0)});
    case (op)
      3'd1: begin
        req = "R2";
        if (m_dep == 8) m_ovf = 1;
        else begin
          m_tok[m_dep] = t; m_tgt[m_dep] = a; m_msk[m_dep] = m_mask; m_els[m_dep] = 0;
          m_dep++; m_mask = m_mask & p;
        end
      end
      3'd2: begin
        req = "R3";
        if (m_dep == 0) m_unf = 1;
        else begin m_mask = m_msk[m_dep-1] & ~m_mask; m_els[m_dep-1] = 1; end
      end
      3'd3: begin
        req = "R4";
        if (m_dep == 0) m_unf = 1;
        else begin m_mask = m_msk[m_dep-1]; m_dep--; end
      end
      3'd4: begin req = "R9"; m_mask = m_mask & ~p; end
      default: req = "R10";
    endcase
    @(posedge clk);
    #2 check_state(req);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_op = '0; pred = '0; tok_in = '0; tgt_in = '0;
    model_reset();
    repeat (2) @(negedge clk);
    do_reset();
    // R10 no-ops with busy inputs
    step(3'd0, 16'h1234, 4'h3, 12'h111);
    step(3'd7, 16'hFFFF, 4'h5, 12'h222);
    // R8 underflow on empty stack
    step(3'd3, 16'h0F0F, 4'h0, 12'h000);
    step(3'd2, 16'h0F0F, 4'h0, 12'h000);
    // R6 nest 8 deep, each frame distinct; then R7 overflow
    for (int i = 0; i < 8; i++)
      step(3'd1, ~(16'h1 << i), 4'(i + 1), 12'(12'h100 + i));
    step(3'd1, 16'hFFFF, 4'hF, 12'hFFF);
    step(3'd2, 16'h00FF, 4'h0, 12'h000);
    for (int i = 0; i < 9; i++) step(3'd3, 16'h0, 4'h0, 12'h000);
    do_reset();
    // R5 skip corners, R2/R3/R4 if-else-reconverge
    step(3'd1, 16'h0000, 4'hA, 12'h0AA);
    step(3'd2, 16'h0000, 4'h0, 12'h000);
    step(3'd3, 16'hFFFF, 4'h0, 12'h000);
    step(3'd1, 16'hFFFF, 4'hB, 12'h0BB);
    step(3'd2, 16'hFFFF, 4'h0, 12'h000);
    step(3'd3, 16'h0, 4'h0, 12'h000);
    // R9 loop exit down to convergence
    step(3'd4, 16'h00F0, 4'h0, 12'h000);
    step(3'd4, 16'hFF0F, 4'h0, 12'h000);
    // pseudo-random sweep
    for (int n = 0; n < 6000; n++) begin
      logic [2:0]  op;
      logic [15:0] p;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: op = 3'd1;
        3'd3:             op = 3'd2;
        3'd4, 3'd5:       op = 3'd3;
        3'd6:             op = (lfsr[9]) ? 3'd4 : 3'd2;
        default:          op = {lfsr[12], 2'b01} ^ 3'b001;
      endcase
      case (lfsr[5:4])
        2'd0:    p = 16'h0000;
        2'd1:    p = 16'hFFFF;
        default: p = lfsr[31:16] ^ lfsr[15:0];
      endcase
      step(op, p, lfsr[11:8], lfsr[27:16]);
      if ((n % 300) == 299) do_reset();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule